// File: doc/BRIEF.md
# 100 Mb/s Carrier Sense Detector

This block produces the carrier sense signal of a 100 Mb/s receive path. It watches the raw received bit stream one bit per clock, before any symbol framing, and declares receive carrier as soon as a zero pattern appears that idle line fill cannot produce. Receive carrier drops again once the line returns to a full run of idle ones.

Carrier sense can optionally also follow local transmit activity. Transmit activity counts only in the default mode. A receive-only selection turns it off. That selection comes from a pin sampled during reset or from a control bit. A repeater-mode input turns it off whatever the selection says. The output is registered, so carrier rises early enough to enclose the receive-data-valid interval that a downstream decoder produces from the same stream.

Top module: `cs100_crs_detect`

## Requirements
- R1: While `rst_n` is low, `crs` is 0 at every clock edge, and the stored history of received bits is set to all ones.
- R2: At the clock edge that samples an `rx_bit` which makes the last 10 sampled bits hold two zeros whose positions differ by 2 or more, receive carrier becomes 1 and `crs` is 1 after that same edge.
- R3: A lone pair of adjacent zeros, with all other bits of the 10-bit history equal to 1, does not raise receive carrier.
- R4: Detection works for any placement of the zeros in the stream. Zeros 9 bit-times apart raise carrier. Zeros 10 bit-times apart, with only ones between them, do not.
- R5: At the edge that samples an `rx_bit` which makes the last 10 sampled bits all ones, receive carrier becomes 0.
- R6: While receive carrier is 1, it stays 1 on every edge where the last 10 bits are not all ones.
- R7: In the default mode (`rxonly_ctrl`, the sampled strap and `repeater_mode` all 0), `crs` after an edge equals receive carrier OR the `tx_active` sampled at that edge.
- R8: With `rxonly_ctrl` = 1, `tx_active` has no effect on `crs`, and receive carrier still drives it.
- R9: `rxonly_strap` is captured on every clock edge while `rst_n` is low and is held after reset. A captured 1 makes `tx_active` ignored. A change of the pin after reset has no effect.
- R10: With `repeater_mode` = 1, `tx_active` has no effect on `crs` regardless of the receive-only selection, and only receive carrier drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one received bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Received serial bit, unaligned |
| tx_active | input | 1 | Local transmit in progress |
| rxonly_strap | input | 1 | Receive-only strap, captured while in reset |
| rxonly_ctrl | input | 1 | Receive-only control bit |
| repeater_mode | input | 1 | Repeater operation, carrier from receive only |
| crs | output | 1 | Carrier sense |

## Verification
The hardest case is the exact edge of the 10-bit window. Two zeros that are 10 bit-times apart must not raise carrier, while zeros 9 apart must. A zero that drops out of the window at the same moment a new zero enters reaches this case only with a precise bit sequence. The vector table therefore flushes the history with ones before every vector and then shifts 20-bit sequences that place zeros at distances 1, 2, 9 and 10. Further vectors let a carrier run for nine ones before a new zero arrives, which exercises the hold-versus-clear decision on the last possible bit.

// File: rtl/cs100_pkg.sv
package cs100_pkg;

  localparam int CS_MAX_W = 32;

  typedef enum logic { CS_QUIET = 1'b0, CS_ACTIVE = 1'b1 } cs_state_e;

  // Two zeros at least two positions apart within the low n bits.
  function automatic logic split_zeros(input logic [CS_MAX_W-1:0] w, input int n);
    logic r;
    r = 1'b0;
    for (int i = 0; i < CS_MAX_W; i++) begin
      for (int j = i + 2; j < CS_MAX_W; j++) begin
        if (i < n && j < n && !w[i] && !w[j]) r = 1'b1;
      end
    end
    return r;
  endfunction

  // Low n bits all ones.
  function automatic logic all_idle(input logic [CS_MAX_W-1:0] w, input int n);
    logic r;
    r = 1'b1;
    for (int i = 0; i < CS_MAX_W; i++) begin
      if (i < n && !w[i]) r = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/cs100_window.sv
module cs100_window
  import cs100_pkg::*;
#(
  parameter int WIN_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit,
  output logic set_evt,
  output logic idle_evt
);
  logic [WIN_W-1:0]    hist_q;
  logic [WIN_W-1:0]    hist_nxt;
  logic [CS_MAX_W-1:0] hist_ext;

  assign hist_nxt = {hist_q[WIN_W-2:0], rx_bit};

  always_comb begin
    hist_ext = '1;
    hist_ext[WIN_W-1:0] = hist_nxt;
  end

  assign set_evt  = split_zeros(hist_ext, WIN_W);
  assign idle_evt = all_idle(hist_ext, WIN_W);

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= '1;
    else        hist_q <= hist_nxt;
  end
endmodule

// File: rtl/cs100_rx_state.sv
module cs100_rx_state
  import cs100_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic idle_evt,
  output logic rx_on_nxt,
  output logic rx_on_q
);
  cs_state_e st_q, st_nxt;

  always_comb begin
    st_nxt = st_q;
    if (set_evt)       st_nxt = CS_ACTIVE;
    else if (idle_evt) st_nxt = CS_QUIET;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= CS_QUIET;
    else        st_q <= st_nxt;
  end

  assign rx_on_nxt = (st_nxt == CS_ACTIVE);
  assign rx_on_q   = (st_q == CS_ACTIVE);
endmodule

// File: rtl/cs100_mode.sv
module cs100_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic rxonly_strap,
  input  logic rxonly_ctrl,
  input  logic repeater_mode,
  output logic tx_pass
);
  logic strap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= rxonly_strap;
  end

  assign tx_pass = !(strap_q | rxonly_ctrl | repeater_mode);
endmodule

// File: rtl/cs100_crs_detect.sv
module cs100_crs_detect #(
  parameter int WIN_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit,
  input  logic tx_active,
  input  logic rxonly_strap,
  input  logic rxonly_ctrl,
  input  logic repeater_mode,
  output logic crs
);
  logic set_evt, idle_evt, rx_on_nxt, rx_on_q, tx_pass;

  cs100_window #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit),
    .set_evt(set_evt), .idle_evt(idle_evt)
  );

  cs100_rx_state u_rx (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .idle_evt(idle_evt),
    .rx_on_nxt(rx_on_nxt), .rx_on_q(rx_on_q)
  );

  cs100_mode u_mode (
    .clk(clk), .rst_n(rst_n), .rxonly_strap(rxonly_strap),
    .rxonly_ctrl(rxonly_ctrl), .repeater_mode(repeater_mode), .tx_pass(tx_pass)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) crs <= 1'b0;
    else        crs <= rx_on_nxt | (tx_active & tx_pass);
  end
endmodule

// File: rtl/cs100_crs_checker.sv
module cs100_crs_checker (
  input logic clk,
  input logic rst_n,
  input logic set_evt,
  input logic idle_evt,
  input logic tx_pass,
  input logic tx_active,
  input logic repeater_mode,
  input logic rx_on_q,
  input logic crs
);
  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> crs);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_evt && !(tx_active && tx_pass)) |=> !crs);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_on_q && !idle_evt) |=> crs);

  assert_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && tx_pass) |=> crs);

  assert_repeater_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (repeater_mode && !rx_on_q && !set_evt) |=> !crs);
endmodule

bind cs100_crs_detect cs100_crs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .idle_evt(idle_evt),
  .tx_pass(tx_pass), .tx_active(tx_active), .repeater_mode(repeater_mode),
  .rx_on_q(rx_on_q), .crs(crs)
);

// File: tb/cs100_crs_detect_tb.sv
`timescale 1ns/1ps
module cs100_crs_detect_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b1, tx_active = 1'b0, rxonly_strap = 1'b0;
  logic rxonly_ctrl = 1'b0, repeater_mode = 1'b0;
  logic crs;
  int   n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  cs100_crs_detect u_dut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .tx_active(tx_active),
    .rxonly_strap(rxonly_strap), .rxonly_ctrl(rxonly_ctrl),
    .repeater_mode(repeater_mode), .crs(crs)
  );

  // stream (MSB first), tx, receive-only bit, repeater, expected crs, tag
  typedef struct packed {
    logic [19:0] bits;
    logic        tx;
    logic        ronly;
    logic        rep;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{20'hFFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},   // R5 idle only
    '{20'hFFFFA, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},   // R2 zeros two apart
    '{20'hFFFFC, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},   // R3 adjacent pair
    '{20'hFFDFE, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4},   // R4 nine apart
    '{20'hFFBFE, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},   // R4 ten apart
    '{20'hFFFF2, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},   // R2 pair plus third
    '{20'h5FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},   // R5 set then clear
    '{20'hFEBFE, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},   // R6 hold on late zero
    '{20'hFFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 4'd7},   // R7 tx only
    '{20'hFFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},   // R8 tx ignored
    '{20'hFFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 4'd10},  // R10 tx ignored
    '{20'hFFFFA, 1'b1, 1'b0, 1'b1, 1'b1, 4'd10},  // R10 rx still counts
    '{20'hFFFFA, 1'b1, 1'b1, 1'b0, 1'b1, 4'd8},   // R8 rx still counts
    '{20'hFFFFC, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8}    // R8 adjacent, no tx
  };

  task automatic check(input logic exp, input string tag);
    n_run++;
    if (crs !== exp) begin
      n_fail++;
      $display("FAIL %s: crs=%b expected %b", tag, crs, exp);
    end
  endtask

  task automatic push(input logic b);
    @(negedge clk);
    rx_bit = b;
    @(posedge clk);
    #1;
  endtask

  task automatic flush();
    @(negedge clk);
    tx_active = 1'b0; rxonly_ctrl = 1'b0; repeater_mode = 1'b0;
    for (int k = 0; k < 10; k++) push(1'b1);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    // R1: reset holds crs low even with transmit active
    tx_active = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(1'b0, "R1 crs in reset");
    @(negedge clk);
    rst_n = 1'b1;
    tx_active = 1'b0;
    // R1: history starts all ones, so one zero does not raise carrier
    push(1'b0);
    check(1'b0, "R1 history all ones");
    flush();

    // R2: exact edge of detection
    push(1'b0);
    check(1'b0, "R2 first zero");
    push(1'b1);
    check(1'b0, "R2 gap bit");
    push(1'b0);
    check(1'b1, "R2 second zero sets");

    for (int v = 0; v < NV; v++) begin
      flush();
      check(1'b0, "R5 flush clears");
      @(negedge clk);
      tx_active = VECS[v].tx;
      rxonly_ctrl = VECS[v].ronly;
      repeater_mode = VECS[v].rep;
      for (int b = 19; b >= 0; b--) push(VECS[v].bits[b]);
      n_run++;
      if (crs !== VECS[v].exp) begin
        n_fail++;
        $display("FAIL R%0d vector %0d: crs=%b expected %b",
                 VECS[v].req, v, crs, VECS[v].exp);
      end
    end

    // R9: strap captured high during reset
    flush();
    @(negedge clk);
    rst_n = 1'b0; rxonly_strap = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1; rxonly_strap = 1'b0; tx_active = 1'b1;
    push(1'b1); push(1'b1);
    check(1'b0, "R9 strap high ignores tx");
    // R9: strap captured low, later pin change has no effect
    @(negedge clk);
    rst_n = 1'b0; rxonly_strap = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1; tx_active = 1'b1;
    push(1'b1);
    check(1'b1, "R9 strap low passes tx");
    @(negedge clk);
    rxonly_strap = 1'b1;
    push(1'b1); push(1'b1);
    check(1'b1, "R9 pin change after reset ignored");

    finish_run();
  end
endmodule